// File: doc/BRIEF.md
# Shader Flow-Control Scope Sequencer

This block produces the fetch address for a small vector shader core and owns the core's control flow. The instruction at the current address is decoded outside the block. Its flow-control class, destination offset, instruction count and an already-evaluated condition bit are handed in on a valid/ready instruction interface. The block keeps a stack of open scopes, one for each pending subroutine call, if/else region or counted loop. A scope has no closing instruction. It closes when the fetch address reaches the scope's recorded final address. At that point the scope either returns to its return address or restarts its body, depending on its remaining repeat count. The block also owns an 8-bit loop register. A loop command loads this register, and every scope closure adds the scope's increment to it.

The instruction interface works as a valid/ready handshake. The block takes the instruction presented at address `pc` in any cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is low before the first start, after a halt, and in every scope-closure cycle, because no instruction executes in those cycles. While `ins_valid` is low the block waits with its address and all state frozen. The driver may hold `ins_valid` high at all times; the instruction fields only have to match the current `pc` in cycles where `ins_ready` is high. A one-cycle `start` pulse restarts sequencing at `start_pc` and overrides everything else in that cycle.

Top module: `shader_flow_seq`

## Requirements
- R1: After reset, `pc`=0, `ins_ready`=0, `done`=0, `overflow`=0 and `loop_reg`=0.
- R2: A `start` pulse loads `pc` with `start_pc`, empties the scope stack and clears `done` and `overflow`. It leaves `loop_reg` unchanged. From the next cycle `ins_ready` is high unless a scope closes.
- R3: An instruction is taken only when `ins_valid` and `ins_ready` are both high. With `ins_valid` low, `pc` holds. A taken plain instruction (class 0 or 7) moves `pc` to `pc`+1.
- R4: A jump (class 1) with the condition true loads `pc` with `ins_dest`. With the condition false it moves to `pc`+1. The stack is not changed in either case.
- R5: A call (class 2, or class 3 with the condition true) opens a scope with start `ins_dest`, final `ins_dest+ins_count`, return `pc`+1, repeat 0 and increment 0, and jumps to `ins_dest`. Class 3 with the condition false moves to `pc`+1.
- R6: When the stack is non-empty and `pc` equals the top scope's final address, `ins_ready` is low for that cycle and `loop_reg` gains the top scope's increment. If the repeat count is 0, `pc` loads the return address and the scope is removed. Otherwise `pc` loads the scope's start address and the repeat count drops by one.
- R7: An if (class 4) with the condition true opens a scope from `pc`+1 to final `ins_dest` that returns to `ins_dest+ins_count`, and moves to `pc`+1. With the condition false it opens a scope from `ins_dest` to final `ins_dest+ins_count` with the same return address, and jumps to `ins_dest`.
- R8: A loop (class 5) loads `loop_reg` with `loop_init` and opens a scope from `pc`+1 to final `ins_dest`+2. The scope returns to `ins_dest`+1, with repeat `loop_repeat` and increment `loop_step`. The body therefore runs `loop_repeat`+1 times.
- R9: An end (class 6) raises `done` and drops `ins_ready`. `pc` holds until the next `start`.
- R10: A scope-opening command that arrives while the stack holds DEPTH scopes pushes nothing and does not load `loop_reg`. It sets `overflow`, which stays high until `start`, and moves `pc` to `pc`+1.
- R11: Only the top scope is compared with `pc`. When a closure returns to an address equal to the final address of the next scope down, a second closure cycle follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse |
| start_pc | input | AW | Address loaded on start |
| ins_valid | input | 1 | Decoded instruction for `pc` is present |
| ins_ready | output | 1 | Block takes the instruction this cycle |
| ins_op | input | 3 | Flow-control class: 0 plain, 1 jump, 2 call, 3 conditional call, 4 if, 5 loop, 6 end, 7 plain |
| ins_cond | input | 1 | Evaluated condition for classes 1, 3 and 4 |
| ins_dest | input | AW | Destination offset |
| ins_count | input | AW | Instruction count |
| loop_repeat | input | LW | Loop repeat value from the integer uniform |
| loop_init | input | LW | Loop register start value |
| loop_step | input | LW | Loop register increment |
| pc | output | AW | Fetch address |
| loop_reg | output | LW | Loop counter register |
| done | output | 1 | Program ended |
| overflow | output | 1 | Sticky scope-stack overflow |

## Verification
The hardest condition to reach from the ports is the back-to-back closure of two scopes. It needs an inner call whose return address is exactly the final address of the enclosing call. The bench builds that layout in a small program table and compares the executed-address trace against one where the shared address never executes. The full-stack case needs eight nested calls whose finals lie beyond the program. The bench then sends a call and a loop while the stack is full, and checks that neither a push nor a change to the loop register occurs.

// File: rtl/shfl_pkg.sv
package shfl_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    FC_STEP  = 3'd0,
    FC_JUMP  = 3'd1,
    FC_CALL  = 3'd2,
    FC_CALLC = 3'd3,
    FC_IF    = 3'd4,
    FC_LOOP  = 3'd5,
    FC_END   = 3'd6,
    FC_SPARE = 3'd7
  } fc_op_e;

endpackage

// File: rtl/shfl_decode_flow.sv
module shfl_decode_flow
  import shfl_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic            cond,
  input  logic [AW-1:0]   cur_pc,
  input  logic [AW-1:0]   dest,
  input  logic [AW-1:0]   count,
  input  logic [LW-1:0]   rep_in,
  input  logic [LW-1:0]   step_in,
  output logic [AW-1:0]   nxt_pc,
  output logic            open_scope,
  output logic [AW-1:0]   s_final,
  output logic [AW-1:0]   s_ret,
  output logic [AW-1:0]   s_start,
  output logic [LW-1:0]   s_rep,
  output logic [LW-1:0]   s_inc,
  output logic            load_loop,
  output logic            halt
);

  fc_op_e        kind;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] dest_end;

  assign kind     = fc_op_e'(op);
  assign seq_pc   = cur_pc + AW'(1);
  assign dest_end = dest + count;

  always_comb begin
    nxt_pc     = seq_pc;
    open_scope = 1'b0;
    s_final    = '0;
    s_ret      = '0;
    s_start    = '0;
    s_rep      = '0;
    s_inc      = '0;
    load_loop  = 1'b0;
    halt       = 1'b0;
    case (kind)
      FC_JUMP: begin
        if (cond) nxt_pc = dest;
      end
      FC_CALL, FC_CALLC: begin
        if (kind == FC_CALL || cond) begin
          open_scope = 1'b1;
          s_start    = dest;
          s_final    = dest_end;
          s_ret      = seq_pc;
          nxt_pc     = dest;
        end
      end
      FC_IF: begin
        open_scope = 1'b1;
        s_ret      = dest_end;
        if (cond) begin
          s_start = seq_pc;
          s_final = dest;
          nxt_pc  = seq_pc;
        end else begin
          s_start = dest;
          s_final = dest_end;
          nxt_pc  = dest;
        end
      end
      FC_LOOP: begin
        open_scope = 1'b1;
        load_loop  = 1'b1;
        s_start    = seq_pc;
        s_final    = dest + AW'(2);
        s_ret      = dest + AW'(1);
        s_rep      = rep_in;
        s_inc      = step_in;
        nxt_pc     = seq_pc;
      end
      FC_END: begin
        halt   = 1'b1;
        nxt_pc = cur_pc;
      end
      default: nxt_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/shfl_scope_stack.sv
module shfl_scope_stack #(
  parameter int AW    = 12,
  parameter int LW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          dec,
  input  logic [AW-1:0] in_final,
  input  logic [AW-1:0] in_ret,
  input  logic [AW-1:0] in_start,
  input  logic [LW-1:0] in_rep,
  input  logic [LW-1:0] in_inc,
  output logic [AW-1:0] top_final,
  output logic [AW-1:0] top_ret,
  output logic [AW-1:0] top_start,
  output logic [LW-1:0] top_rep,
  output logic [LW-1:0] top_inc,
  output logic          empty,
  output logic          full
);

  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] used_q;
  logic [PW-1:0] top_idx;

  logic [AW-1:0] fin_w [DEPTH];
  logic [AW-1:0] ret_w [DEPTH];
  logic [AW-1:0] sta_w [DEPTH];
  logic [LW-1:0] rep_w [DEPTH];
  logic [LW-1:0] inc_w [DEPTH];

  assign top_idx = used_q - PW'(1);
  assign empty   = (used_q == '0);
  assign full    = (used_q == PW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (clear) begin
      used_q <= '0;
    end else if (push) begin
      used_q <= used_q + PW'(1);
    end else if (pop) begin
      used_q <= used_q - PW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [AW-1:0] fin_q;
    logic [AW-1:0] ret_q;
    logic [AW-1:0] sta_q;
    logic [LW-1:0] rep_q;
    logic [LW-1:0] inc_q;
    logic          wr_hit;
    logic          dec_hit;

    assign wr_hit  = push && (used_q == PW'(g));
    assign dec_hit = dec && !empty && (top_idx == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fin_q <= '0;
        ret_q <= '0;
        sta_q <= '0;
        rep_q <= '0;
        inc_q <= '0;
      end else if (wr_hit) begin
        fin_q <= in_final;
        ret_q <= in_ret;
        sta_q <= in_start;
        rep_q <= in_rep;
        inc_q <= in_inc;
      end else if (dec_hit) begin
        rep_q <= rep_q - LW'(1);
      end
    end

    assign fin_w[g] = fin_q;
    assign ret_w[g] = ret_q;
    assign sta_w[g] = sta_q;
    assign rep_w[g] = rep_q;
    assign inc_w[g] = inc_q;
  end

  always_comb begin
    top_final = '0;
    top_ret   = '0;
    top_start = '0;
    top_rep   = '0;
    top_inc   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!empty && top_idx == PW'(i)) begin
        top_final = fin_w[i];
        top_ret   = ret_w[i];
        top_start = sta_w[i];
        top_rep   = rep_w[i];
        top_inc   = inc_w[i];
      end
    end
  end

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || dec) |-> !empty) else $error("close with empty stack"); // R6

  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full stack"); // R10

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= PW'(DEPTH)) else $error("depth beyond limit"); // R10

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && (pop || dec))) else $error("open and close together"); // R6

endmodule

// File: rtl/shfl_loop_reg.sv
module shfl_loop_reg #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [LW-1:0] add_val,
  input  logic          load_en,
  input  logic [LW-1:0] load_val,
  output logic [LW-1:0] value
);

  logic [LW-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load_en) begin
      val_q <= load_val;
    end else if (add_en) begin
      val_q <= val_q + add_val;
    end
  end

  assign value = val_q;

  AST_LOOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_en && load_en)) else $error("loop load during closure"); // R8

  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !load_en) |=> (value == $past(value))) else $error("loop reg drift"); // R10

endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
  import shfl_pkg::*;
#(
  parameter int AW    = 12,
  parameter int LW    = 8,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_pc,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [OP_W-1:0] ins_op,
  input  logic            ins_cond,
  input  logic [AW-1:0]   ins_dest,
  input  logic [AW-1:0]   ins_count,
  input  logic [LW-1:0]   loop_repeat,
  input  logic [LW-1:0]   loop_init,
  input  logic [LW-1:0]   loop_step,
  output logic [AW-1:0]   pc,
  output logic [LW-1:0]   loop_reg,
  output logic            done,
  output logic            overflow
);

  logic [AW-1:0] pc_q;
  logic          run_q;
  logic          done_q;
  logic          ovf_q;

  logic [AW-1:0] d_nxt;
  logic          d_open;
  logic [AW-1:0] d_final;
  logic [AW-1:0] d_ret;
  logic [AW-1:0] d_start;
  logic [LW-1:0] d_rep;
  logic [LW-1:0] d_inc;
  logic          d_load;
  logic          d_halt;

  logic [AW-1:0] t_final;
  logic [AW-1:0] t_ret;
  logic [AW-1:0] t_start;
  logic [LW-1:0] t_rep;
  logic [LW-1:0] t_inc;
  logic          st_empty;
  logic          st_full;

  logic          at_close;
  logic          close_go;
  logic          fire_go;
  logic          push_go;
  logic          push_drop;
  logic          last_pass;

  assign at_close  = run_q && !st_empty && (pc_q == t_final);
  assign ins_ready = run_q && !at_close;
  assign close_go  = at_close && !start;
  assign fire_go   = ins_valid && ins_ready && !start;
  assign push_go   = fire_go && d_open && !st_full;
  assign push_drop = fire_go && d_open && st_full;
  assign last_pass = (t_rep == '0);

  shfl_decode_flow #(.AW(AW), .LW(LW)) u_decode (
    .op        (ins_op),
    .cond      (ins_cond),
    .cur_pc    (pc_q),
    .dest      (ins_dest),
    .count     (ins_count),
    .rep_in    (loop_repeat),
    .step_in   (loop_step),
    .nxt_pc    (d_nxt),
    .open_scope(d_open),
    .s_final   (d_final),
    .s_ret     (d_ret),
    .s_start   (d_start),
    .s_rep     (d_rep),
    .s_inc     (d_inc),
    .load_loop (d_load),
    .halt      (d_halt)
  );

  shfl_scope_stack #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .push     (push_go),
    .pop      (close_go && last_pass),
    .dec      (close_go && !last_pass),
    .in_final (d_final),
    .in_ret   (d_ret),
    .in_start (d_start),
    .in_rep   (d_rep),
    .in_inc   (d_inc),
    .top_final(t_final),
    .top_ret  (t_ret),
    .top_start(t_start),
    .top_rep  (t_rep),
    .top_inc  (t_inc),
    .empty    (st_empty),
    .full     (st_full)
  );

  shfl_loop_reg #(.LW(LW)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (close_go),
    .add_val (t_inc),
    .load_en (fire_go && d_load && !st_full),
    .load_val(loop_init),
    .value   (loop_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (start) begin
      pc_q   <= start_pc;
      run_q  <= 1'b1;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (close_go) begin
      pc_q <= last_pass ? t_ret : t_start;
    end else if (fire_go) begin
      if (d_halt) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (push_drop) begin
        pc_q  <= pc_q + AW'(1);
        ovf_q <= 1'b1;
      end else begin
        pc_q <= d_nxt;
      end
    end
  end

  assign pc       = pc_q;
  assign done     = done_q;
  assign overflow = ovf_q;

  AST_HALT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ins_ready) else $error("ready while halted"); // R9

  AST_HALT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(pc)) else $error("pc moved while halted"); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && !ins_valid && !start) |=> $stable(pc)) else $error("pc moved on stall"); // R3

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && ins_valid && !start && (ins_op == 3'd0)) |=> (pc == $past(pc) + AW'(1)))
    else $error("plain step wrong"); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow) else $error("overflow dropped"); // R10

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !overflow && pc == $past(start_pc))) else $error("start load wrong"); // R2

endmodule

// File: tb/test_shader_flow_seq.sv
`timescale 1ns/1ps
module test_shader_flow_seq;

  localparam int AW = 12;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_pc = '0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [2:0]    ins_op = '0;
  logic          ins_cond = 1'b0;
  logic [AW-1:0] ins_dest = '0;
  logic [AW-1:0] ins_count = '0;
  logic [LW-1:0] loop_repeat = '0;
  logic [LW-1:0] loop_init = '0;
  logic [LW-1:0] loop_step = '0;
  logic [AW-1:0] pc;
  logic [LW-1:0] loop_reg;
  logic          done;
  logic          overflow;

  shader_flow_seq #(.AW(AW), .LW(LW), .DEPTH(8)) i_shader_flow_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op),
    .ins_cond(ins_cond), .ins_dest(ins_dest), .ins_count(ins_count),
    .loop_repeat(loop_repeat), .loop_init(loop_init), .loop_step(loop_step),
    .pc(pc), .loop_reg(loop_reg), .done(done), .overflow(overflow)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  logic [2:0]    p_op   [64];
  logic          p_cond [64];
  logic [AW-1:0] p_dest [64];
  logic [AW-1:0] p_cnt  [64];
  logic [LW-1:0] p_rep  [64];
  logic [LW-1:0] p_init [64];
  logic [LW-1:0] p_step [64];
  bit            stall = 1'b1;

  int trace [64];
  int tcnt = 0;
  int expv  [64];
  int ecnt = 0;

  always @(negedge clk) begin
    int a;
    a = int'(pc[5:0]);
    ins_valid   = !stall;
    ins_op      = p_op[a];
    ins_cond    = p_cond[a];
    ins_dest    = p_dest[a];
    ins_count   = p_cnt[a];
    loop_repeat = p_rep[a];
    loop_init   = p_init[a];
    loop_step   = p_step[a];
    if (rst_n && !stall && ins_ready && tcnt < 64) begin
      trace[tcnt] = int'(pc);
      tcnt = tcnt + 1;
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin
      p_op[i] = 3'd0; p_cond[i] = 1'b0; p_dest[i] = '0; p_cnt[i] = '0;
      p_rep[i] = '0; p_init[i] = '0; p_step[i] = '0;
    end
    ecnt = 0;
  endtask

  task automatic put(input int a, input int op, input int cond, input int dest, input int cnt);
    p_op[a] = 3'(op); p_cond[a] = cond[0]; p_dest[a] = AW'(dest); p_cnt[a] = AW'(cnt);
  endtask

  task automatic ex(input int v);
    expv[ecnt] = v;
    ecnt++;
  endtask

  task automatic do_start(input int addr);
    @(posedge clk); #1;
    start = 1'b1; start_pc = AW'(addr);
    @(posedge clk); #1;
    start = 1'b0;
    tcnt = 0;
  endtask

  task automatic run_to_done(input string req);
    int n;
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk({req, " reaches end"}, int'(done), 1);
    @(negedge clk);
  endtask

  task automatic cmp_trace(input string req);
    chk({req, " trace length"}, tcnt, ecnt);
    for (int i = 0; i < ecnt && i < tcnt; i++) chk({req, " trace entry"}, trace[i], expv[i]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pc", int'(pc), 0);
    chk("R1 ready", int'(ins_ready), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 loop_reg", int'(loop_reg), 0);
  endtask

  task automatic t_stall();
    clear_prog();
    stall = 1'b1;
    do_start(5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 ready after start", int'(ins_ready), 1);
      chk("R3 pc held on stall", int'(pc), 5);
    end
    @(posedge clk); #1; stall = 1'b0;
    @(posedge clk); #1; stall = 1'b1;
    @(negedge clk);
    chk("R3 plain step", int'(pc), 6);
  endtask

  task automatic t_jump_call();
    clear_prog();
    put(11, 1, 0, 30, 0);
    put(12, 1, 1, 20, 0);
    put(20, 2, 0, 40, 2);
    put(21, 3, 0, 40, 2);
    put(22, 3, 1, 44, 1);
    put(23, 6, 0, 0, 0);
    ex(10); ex(11); ex(12); ex(20); ex(40); ex(41); ex(21); ex(22); ex(44); ex(23);
    stall = 1'b0;
    do_start(10);
    run_to_done("R5");
    cmp_trace("R4 R5 R6 jump and call");
    chk("R9 ready low after end", int'(ins_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 pc held after end", int'(pc), 23);
  endtask

  task automatic t_if();
    clear_prog();
    put(0, 4, 1, 3, 2);
    put(5, 4, 0, 8, 1);
    put(9, 6, 0, 0, 0);
    ex(0); ex(1); ex(2); ex(5); ex(8); ex(9);
    do_start(0);
    run_to_done("R7");
    cmp_trace("R7 if true and false");
  endtask

  task automatic t_loop();
    clear_prog();
    put(0, 5, 0, 2, 0);
    p_rep[0] = 8'd2; p_init[0] = 8'd10; p_step[0] = 8'd3;
    put(4, 6, 0, 0, 0);
    ex(0); ex(1); ex(2); ex(3); ex(1); ex(2); ex(3); ex(1); ex(2); ex(3); ex(3); ex(4);
    do_start(0);
    @(negedge clk); @(negedge clk);
    chk("R8 loop_reg loaded", int'(loop_reg), 10);
    run_to_done("R8");
    cmp_trace("R8 R6 loop passes");
    chk("R6 loop_reg after closures", int'(loop_reg), 19);
  endtask

  task automatic t_nested();
    clear_prog();
    put(0, 2, 0, 10, 2);
    put(11, 2, 0, 20, 1);
    put(1, 6, 0, 0, 0);
    ex(0); ex(10); ex(11); ex(20); ex(1);
    do_start(0);
    run_to_done("R11");
    cmp_trace("R11 back-to-back closure");
  endtask

  task automatic t_overflow();
    clear_prog();
    for (int a = 0; a < 9; a++) put(a, 2, 0, a + 1, 50);
    put(9, 5, 0, 3, 0);
    p_init[9] = 8'd99; p_rep[9] = 8'd1; p_step[9] = 8'd1;
    put(10, 6, 0, 0, 0);
    for (int a = 0; a <= 10; a++) ex(a);
    do_start(0);
    chk("R10 overflow clear before", int'(overflow), 0);
    run_to_done("R10");
    cmp_trace("R10 dropped pushes");
    chk("R10 overflow set", int'(overflow), 1);
    chk("R10 loop_reg untouched", int'(loop_reg), 19);
    clear_prog();
    put(0, 6, 0, 0, 0);
    do_start(0);
    @(negedge clk);
    chk("R2 start clears overflow", int'(overflow), 0);
    chk("R2 start keeps loop_reg", int'(loop_reg), 19);
    run_to_done("R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    clear_prog();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_stall();
    t_jump_call();
    t_if();
    t_loop();
    t_nested();
    t_overflow();
    report();
    $finish;
  end

endmodule